// File: doc/BRIEF.md
# Configuration EEPROM Access Controller

This block sits between a host register port and an external serial configuration EEPROM of 64 sixteen-bit words. It serves two purposes. A host can move one word at a time through a general-purpose data register, addressed by a pointer register. It can also copy a small bank of device configuration words from the EEPROM, or back into it, in a single command. The control register also holds two device-level bits: a bad-CRC receive enable and a power-down bit.

The host starts transfers by setting a store (write) or load (read) command bit in the control register. A select bit in the same write decides the target. With select set to 1, the command moves one word between the data register and the EEPROM word named by the pointer's low six bits. With select set to 0, the command walks the configuration bank starting at word 0. A bank store skips the protected station-address words. Those words can be programmed only through the general-purpose path.

The serial side is a four-wire port: select, clock and data-out to the EEPROM, plus data-in from it. Each bit takes `2*SK_HALF` system cycles. Every write is preceded by a write-enable frame. After a write, the block polls the EEPROM ready line until it goes high or a cycle limit is reached.

Top module: `cfg_eeprom_ctrl`

Sequencer states: `C_IDLE`, `C_EWEN_GO`, `C_EWEN_WAIT`, `C_XFER_GO`, `C_XFER_WAIT`, `C_FINISH`.
- `C_IDLE` moves to `C_XFER_GO` on a load command, or to `C_EWEN_GO` on a store command.
- `C_EWEN_GO` moves to `C_EWEN_WAIT`, which moves to `C_XFER_GO` when its frame ends.
- `C_XFER_GO` moves to `C_XFER_WAIT`.
- `C_XFER_WAIT` moves to `C_FINISH` after a single-word transfer or the last bank word. Otherwise it returns to `C_XFER_GO` for the next bank word.
- `C_FINISH` moves to `C_IDLE`.

Serial engine states: `S_IDLE`, `S_SHIFT`, `S_GAP`, `S_POLL`.
- `S_IDLE` moves to `S_SHIFT` on start.
- `S_SHIFT` moves to `S_IDLE` after a read or enable frame, or to `S_GAP` after a write frame.
- `S_GAP` moves to `S_POLL` after one bit time with select low.
- `S_POLL` moves to `S_IDLE` when the ready line is high or the cycle limit expires.

## Requirements
- R1: After reset the control register reads 0x0010, so power-down is 1 and every other bit is 0. The data and pointer registers read 0, and `busy`, `rcv_bad` and `ee_cs` are 0. Register addresses are 0 = data, 1 = pointer, 2 = control, 3 = configuration window.
- R2: `pwrdn` (control bit 4) becomes 0 one cycle after any host write to the data, pointer or window register. A write to the control register loads bit 4 from the written value. Without a host write, `pwrdn` does not change.
- R3: A single-word load command (control bits 2 and 1 set) sends a 9-bit header, most significant bit first: start bit 1, opcode 10, then pointer bits 5..0. It then shifts in 16 data bits, MSB first, sampled on rising `ee_sk`, and places the word in the data register. `ee_sk` is low whenever `ee_cs` is low.
- R4: A single-word store command (control bits 2 and 0 set) sends a write-enable frame first: opcode 00 with address 11xxxx. It then sends a write frame: start 1, opcode 01, the address, then the data register's 16 bits. Finally it waits for `ee_do` to go high.
- R5: While a transfer runs, `busy` (control bit 15) reads 1 and the active command bit reads 1. Both clear by themselves when the transfer completes.
- R6: A control write while `busy` is 1 starts nothing and changes neither the command bits nor the select bit. `busy` only rises after a control write.
- R7: If store and load are written as 1 in the same write, only the load is performed.
- R8: A bank load (select 0, bit 1) reads EEPROM words 0..CFG_WORDS-1 into configuration words 0..CFG_WORDS-1. Each configuration word can be read and written through the window register, indexed by the pointer's low bits.
- R9: A bank store (select 0, bit 0) writes every configuration word to the EEPROM word of the same number, except words PROT_LO..PROT_HI (2..4 by default), which stay unchanged. PROT_LO must be above 0.
- R10: A single-word store can write a protected word.
- R11: If `ee_do` never goes high after a write, `busy` still clears, between TMO_CYC and TMO_CYC+300 cycles after the command. A store with a prompt ready signal finishes in fewer than TMO_CYC cycles.
- R12: Control bit 3 is readable and writable, and drives the `rcv_bad` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 2 | Register select |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |
| pwrdn | output | 1 | Power-down request |
| rcv_bad | output | 1 | Accept packets with bad CRC |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to EEPROM |
| ee_do | input | 1 | Serial data / ready from EEPROM |

## Verification
The transfer engine is tried with a single-word load and a single-word store to an unprotected address. These show whether the header bits, the opcode and the bit order match on both directions. A single-word store to a protected address, followed by a bank store, shows whether protection applies only on the bank path. A simultaneous store+load write, and a command issued while busy, separate priority from ignore behaviour. An EEPROM model that never signals ready tells the timeout exit apart from the normal ready exit.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_PTR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_CFG  = 2'd3
    } reg_sel_e;

    localparam int BIT_STORE  = 0;
    localparam int BIT_RELOAD = 1;
    localparam int BIT_SEL    = 2;
    localparam int BIT_RCVBAD = 3;
    localparam int BIT_PWRDN  = 4;

    typedef enum logic [1:0] {
        OP_EWEN  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } ser_op_e;

    typedef enum logic [2:0] {
        C_IDLE, C_EWEN_GO, C_EWEN_WAIT, C_XFER_GO, C_XFER_WAIT, C_FINISH
    } ctl_state_e;

    typedef enum logic [1:0] {
        S_IDLE, S_SHIFT, S_GAP, S_POLL
    } ser_state_e;
endpackage

// File: rtl/eeprom_serial_eng.sv
module eeprom_serial_eng
    import cfgrom_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DW      = 16,
    parameter int SK_HALF = 2,
    parameter int TMO_CYC = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  ser_op_e       op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          ser_cs,
    output logic          ser_sk,
    output logic          ser_di,
    input  logic          ser_do
);
    localparam int HDR   = 3 + AW;
    localparam int FRAME = HDR + DW;
    localparam int CW    = $clog2(FRAME + 1);
    localparam int TW    = $clog2(TMO_CYC + 1);
    localparam int PHW   = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;

    ser_state_e       state_q, state_d;
    logic [PHW-1:0]   ph_q;
    logic             skh_q;
    logic [CW-1:0]    bit_q, last_q;
    logic [FRAME-1:0] tx_q;
    logic [DW-1:0]    rx_q;
    logic             wr_q;
    logic [TW-1:0]    tmo_q;
    logic             ph_end, frame_end, poll_end;

    assign ph_end    = (ph_q == PHW'(SK_HALF - 1));
    assign frame_end = (state_q == S_SHIFT) && ph_end && skh_q && (bit_q == last_q);
    assign poll_end  = (state_q == S_POLL) && (ser_do || (tmo_q == TW'(TMO_CYC - 1)));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_SHIFT;
            S_SHIFT: if (frame_end) state_d = wr_q ? S_GAP : S_IDLE;
            S_GAP:   if (ph_end && skh_q) state_d = S_POLL;
            S_POLL:  if (poll_end) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            skh_q  <= 1'b0;
            bit_q  <= '0;
            last_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            wr_q   <= 1'b0;
            tmo_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        tx_q   <= {1'b1, op, addr, (op == OP_WRITE) ? wdata : {DW{1'b0}}};
                        bit_q  <= '0;
                        ph_q   <= '0;
                        skh_q  <= 1'b0;
                        last_q <= (op == OP_EWEN) ? CW'(HDR - 1) : CW'(FRAME - 1);
                        wr_q   <= (op == OP_WRITE);
                    end
                end
                S_SHIFT, S_GAP: begin
                    ph_q  <= ph_end ? '0 : ph_q + 1'b1;
                    tmo_q <= '0;
                    if (ph_end) skh_q <= ~skh_q;
                    if (state_q == S_SHIFT && ph_end) begin
                        if (!skh_q) begin
                            rx_q <= {rx_q[DW-2:0], ser_do};
                        end else begin
                            tx_q  <= tx_q << 1;
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                S_POLL: tmo_q <= tmo_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign done   = (frame_end && !wr_q) || poll_end;
    assign rdata  = rx_q;
    assign ser_cs = (state_q == S_SHIFT) || (state_q == S_POLL);
    assign ser_sk = (state_q == S_SHIFT) && skh_q;
    assign ser_di = (state_q == S_SHIFT) && tx_q[FRAME-1];
endmodule

// File: rtl/cfg_eeprom_ctrl.sv
module cfg_eeprom_ctrl
    import cfgrom_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 16,
    parameter int CFG_WORDS = 8,
    parameter int PROT_LO   = 2,
    parameter int PROT_HI   = 4,
    parameter int SK_HALF   = 2,
    parameter int TMO_CYC   = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          busy,
    output logic          pwrdn,
    output logic          rcv_bad,
    output logic          ee_cs,
    output logic          ee_sk,
    output logic          ee_di,
    input  logic          ee_do
);
    localparam int IW = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;

    ctl_state_e    state_q, state_d;
    logic [DW-1:0] data_q, ptr_q;
    logic [DW-1:0] cfg_q [CFG_WORDS];
    logic          store_q, reload_q, sel_q, rcvbad_q, pwrdn_q;
    logic [IW-1:0] idx_q;
    logic [IW:0]   idx_nxt;
    logic          ctrl_wr, launch, seq_last;
    logic          eng_start, eng_done;
    ser_op_e       eng_op;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_wdata, eng_rdata, ctrl_rd;

    assign ctrl_wr = host_wr && (host_addr == REG_CTRL);
    assign launch  = ctrl_wr && (state_q == C_IDLE) &&
                     (host_wdata[BIT_RELOAD] || host_wdata[BIT_STORE]);

    always_comb begin
        idx_nxt = {1'b0, idx_q} + 1'b1;
        if (store_q && idx_nxt >= (IW+1)'(PROT_LO) && idx_nxt <= (IW+1)'(PROT_HI))
            idx_nxt = (IW+1)'(PROT_HI + 1);
    end
    assign seq_last = (idx_nxt >= (IW+1)'(CFG_WORDS));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:      if (launch) state_d = host_wdata[BIT_RELOAD] ? C_XFER_GO : C_EWEN_GO;
            C_EWEN_GO:   state_d = C_EWEN_WAIT;
            C_EWEN_WAIT: if (eng_done) state_d = C_XFER_GO;
            C_XFER_GO:   state_d = C_XFER_WAIT;
            C_XFER_WAIT: if (eng_done) state_d = (sel_q || seq_last) ? C_FINISH : C_XFER_GO;
            C_FINISH:    state_d = C_IDLE;
            default:     state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            ptr_q    <= '0;
            store_q  <= 1'b0;
            reload_q <= 1'b0;
            sel_q    <= 1'b0;
            rcvbad_q <= 1'b0;
            pwrdn_q  <= 1'b1;
            idx_q    <= '0;
            for (int i = 0; i < CFG_WORDS; i++) cfg_q[i] <= '0;
        end else begin
            if (host_wr) pwrdn_q <= ctrl_wr ? host_wdata[BIT_PWRDN] : 1'b0;
            if (ctrl_wr) begin
                rcvbad_q <= host_wdata[BIT_RCVBAD];
                if (state_q == C_IDLE) sel_q <= host_wdata[BIT_SEL];
            end
            if (launch) begin
                reload_q <= host_wdata[BIT_RELOAD];
                store_q  <= host_wdata[BIT_STORE] && !host_wdata[BIT_RELOAD];
                idx_q    <= '0;
            end
            if (host_wr && host_addr == REG_DATA) data_q <= host_wdata;
            if (host_wr && host_addr == REG_PTR)  ptr_q  <= host_wdata;
            if (host_wr && host_addr == REG_CFG)  cfg_q[ptr_q[IW-1:0]] <= host_wdata;
            if (state_q == C_XFER_WAIT && eng_done) begin
                if (reload_q) begin
                    if (sel_q) data_q <= eng_rdata;
                    else       cfg_q[idx_q] <= eng_rdata;
                end
                if (!sel_q) idx_q <= idx_nxt[IW-1:0];
            end
            if (state_q == C_FINISH) begin
                store_q  <= 1'b0;
                reload_q <= 1'b0;
            end
        end
    end

    assign eng_start = (state_q == C_EWEN_GO) || (state_q == C_XFER_GO);
    assign eng_op    = (state_q == C_EWEN_GO) ? OP_EWEN : (store_q ? OP_WRITE : OP_READ);
    assign eng_addr  = (state_q == C_EWEN_GO) ? {2'b11, {(AW-2){1'b0}}} :
                       (sel_q ? ptr_q[AW-1:0] : AW'(idx_q));
    assign eng_wdata = sel_q ? data_q : cfg_q[idx_q];

    eeprom_serial_eng #(
        .AW(AW), .DW(DW), .SK_HALF(SK_HALF), .TMO_CYC(TMO_CYC)
    ) eng_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .op     (eng_op),
        .addr   (eng_addr),
        .wdata  (eng_wdata),
        .done   (eng_done),
        .rdata  (eng_rdata),
        .ser_cs (ee_cs),
        .ser_sk (ee_sk),
        .ser_di (ee_di),
        .ser_do (ee_do)
    );

    assign busy    = (state_q != C_IDLE);
    assign pwrdn   = pwrdn_q;
    assign rcv_bad = rcvbad_q;

    always_comb begin
        ctrl_rd             = '0;
        ctrl_rd[BIT_STORE]  = store_q;
        ctrl_rd[BIT_RELOAD] = reload_q;
        ctrl_rd[BIT_SEL]    = sel_q;
        ctrl_rd[BIT_RCVBAD] = rcvbad_q;
        ctrl_rd[BIT_PWRDN]  = pwrdn_q;
        ctrl_rd[DW-1]       = busy;
    end

    always_comb begin
        unique case (host_addr)
            REG_DATA: host_rdata = data_q;
            REG_PTR:  host_rdata = ptr_q;
            REG_CTRL: host_rdata = ctrl_rd;
            default:  host_rdata = cfg_q[ptr_q[IW-1:0]];
        endcase
    end
endmodule

// File: rtl/cfg_eeprom_chk.sv
module cfg_eeprom_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic [1:0] host_addr,
    input logic       busy,
    input logic       pwrdn,
    input logic       ee_cs,
    input logic       ee_sk
);
    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_cs);

    // R3
    sk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    // R2
    pwrdn_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != 2'd2) |=> !pwrdn);

    // R2
    pwrdn_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(pwrdn));

    // R6
    busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_wr && host_addr == 2'd2));
endmodule

bind cfg_eeprom_ctrl cfg_eeprom_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .busy      (busy),
    .pwrdn     (pwrdn),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk)
);

// File: tb/cfg_eeprom_ctrl_tb.sv
module cfg_eeprom_ctrl_tb_top;
    localparam int TMO = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        busy, pwrdn, rcv_bad, ee_cs, ee_sk, ee_di, ee_do;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cfg_eeprom_ctrl #(.TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .pwrdn(pwrdn), .rcv_bad(rcv_bad), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(ee_do)
    );

    // serial EEPROM model
    logic [15:0] m_mem [64];
    logic [24:0] m_sh = '0;
    logic [8:0]  m_hdr = '0;
    logic [15:0] m_word = '0;
    int  m_cnt = 0;
    int  m_busy = 0;
    bit  m_arm = 0, m_rd = 0, m_bit = 0, m_ewen = 0, m_stuck = 0;

    always @(posedge ee_sk) if (ee_cs) begin
        m_sh = {m_sh[23:0], ee_di};
        m_cnt++;
        if (m_cnt == 9) begin
            m_hdr = m_sh[8:0];
            if (m_sh[7:6] == 2'b10) begin
                m_word = m_mem[m_sh[5:0]];
                m_arm  = 1;
            end
        end
    end
    always @(negedge ee_sk) if (m_arm) begin
        m_bit  = m_word[15];
        m_word = {m_word[14:0], 1'b0};
        m_rd   = 1;
    end
    always @(negedge ee_cs) begin
        if (m_cnt == 9 && m_sh[7:6] == 2'b00 && m_sh[5:4] == 2'b11) m_ewen = 1;
        if (m_cnt == 25 && m_sh[23:22] == 2'b01 && m_ewen) begin
            m_mem[m_sh[21:16]] = m_sh[15:0];
            m_busy = 20;
        end
        m_cnt = 0; m_arm = 0; m_rd = 0;
    end
    always @(posedge clk) if (m_busy > 0) m_busy--;
    assign ee_do = m_rd ? m_bit : (ee_cs && m_busy == 0 && !m_stuck);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    typedef struct packed {
        logic [1:0]  a;
        logic [15:0] d;
        logic [15:0] exp;
        logic        pd;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd2, 16'h0010, 16'h0010, 1'b1},
        '{2'd0, 16'h5A5A, 16'h5A5A, 1'b0},
        '{2'd2, 16'h0018, 16'h0018, 1'b1},
        '{2'd1, 16'h00C5, 16'h00C5, 1'b0},
        '{2'd3, 16'h1357, 16'h1357, 1'b0},
        '{2'd2, 16'h0000, 16'h0000, 1'b0}
    };

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] saved [3];
        int cyc;
        for (int i = 0; i < 64; i++) m_mem[i] = 16'h3C00 + 16'(i) * 16'h0111;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd2, v); check("R1 ctrl", v, 16'h0010);
        rd(2'd0, v); check("R1 data", v, 16'h0000);
        rd(2'd1, v); check("R1 ptr", v, 16'h0000);
        check("R1 busy/cs/rcv_bad", {busy, ee_cs, rcv_bad}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R12 R8 register vectors
        foreach (VECS[k]) begin
            wr(VECS[k].a, VECS[k].d);
            rd(VECS[k].a, v);
            check($sformatf("R2/R12/R8 vec%0d read", k), v, VECS[k].exp);
            check($sformatf("R2 vec%0d pwrdn", k), pwrdn, VECS[k].pd);
            if (VECS[k].a == 2'd2) check("R12 rcv_bad pin", rcv_bad, VECS[k].d[3]);
        end

        // R3 R5 single-word load
        wr(2'd1, 16'h0027);
        wr(2'd2, 16'h0006);
        rd(2'd2, v); check("R5 busy+cmd during load", v & 16'h8002, 16'h8002);
        wait_idle(cyc);
        rd(2'd0, v); check("R3 loaded word", v, m_mem[39]);
        check("R3 header", m_hdr, 9'b110100111);
        rd(2'd2, v); check("R5 self clear", v, 16'h0004);

        // R4 R11 single-word store
        wr(2'd0, 16'hC0DE);
        wr(2'd1, 16'h000A);
        wr(2'd2, 16'h0005);
        wait_idle(cyc);
        check("R4 stored word", m_mem[10], 16'hC0DE);
        check("R4 enable frame seen", m_ewen, 1'b1);
        check("R11 prompt ready shorter than limit", cyc < TMO, 1'b1);

        // R10 protected word via general path
        wr(2'd0, 16'h0A0B);
        wr(2'd1, 16'h0003);
        wr(2'd2, 16'h0005);
        wait_idle(cyc);
        check("R10 protected word written", m_mem[3], 16'h0A0B);

        // R6 command while busy
        wr(2'd1, 16'h0014);
        wr(2'd2, 16'h0006);
        wr(2'd2, 16'h0001);
        wait_idle(cyc);
        repeat (4) @(negedge clk);
        check("R6 no second transfer", busy, 1'b0);
        rd(2'd0, v); check("R6 load result kept", v, m_mem[20]);
        rd(2'd2, v); check("R6 select kept", v, 16'h0004);

        // R7 priority
        wr(2'd0, 16'hFFFF);
        wr(2'd1, 16'h000B);
        wr(2'd2, 16'h0007);
        wait_idle(cyc);
        check("R7 no write", m_mem[11], 16'h3C00 + 16'd11 * 16'h0111);
        rd(2'd0, v); check("R7 load done", v, m_mem[11]);

        // R8 bank load
        wr(2'd2, 16'h0002);
        wait_idle(cyc);
        for (int i = 0; i < 8; i++) begin
            wr(2'd1, 16'(i));
            rd(2'd3, v); check($sformatf("R8 cfg%0d", i), v, m_mem[i]);
        end

        // R9 bank store
        for (int i = 0; i < 8; i++) begin
            wr(2'd1, 16'(i));
            wr(2'd3, 16'h7000 + 16'(i));
        end
        for (int i = 0; i < 3; i++) saved[i] = m_mem[i + 2];
        wr(2'd2, 16'h0001);
        wait_idle(cyc);
        for (int i = 0; i < 8; i++) begin
            if (i >= 2 && i <= 4) check($sformatf("R9 protected %0d", i), m_mem[i], saved[i - 2]);
            else                  check($sformatf("R9 word %0d", i), m_mem[i], 16'h7000 + 16'(i));
        end

        // R11 ready timeout
        m_stuck = 1;
        wr(2'd0, 16'h1111);
        wr(2'd1, 16'h001E);
        wr(2'd2, 16'h0005);
        wait_idle(cyc);
        check("R11 busy cleared", busy, 1'b0);
        check("R11 timeout window", (cyc >= TMO) && (cyc <= TMO + 300), 1'b1);
        m_stuck = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule